// File: doc/BRIEF.md
# Dual-Channel Event Performance Counter

This block watches a processor model and counts selected activity on two independent channels. Every cycle the processor model presents a vector of one-cycle event pulses: instruction retired, unconditional branch, instruction cache access and miss, operand cache read access and miss. It also presents a level that is high while the processor runs in privileged mode. Each channel has a control register. That register holds an event-select code, two configuration bits and a start bit. While a channel runs, its counter adds one for every cycle in which the selected event is present.

Software drives the block through one write port and one independent, combinational read port, both addressed by word index. Configuration happens in three steps. First a write to the shared status register clears the channel. Next a control write sets the event code together with the two configuration bits. Last, a separate control write sets the start bit. When a counter wraps past its all-ones value, a sticky overflow flag is raised in the shared status register. Writing that channel's clear bit resets both the count and the flag.

Each channel runs a small state machine. IDLE means not configured. ARMED means both configuration bits are set but the channel is not started. COUNTING means the start bit is set. Every control write picks the next state from the written bits, whatever the current state: start=1 leads to COUNTING; start=0 with both configuration bits set leads to ARMED; anything else leads to IDLE. The named transitions are IDLE->ARMED (configure), IDLE->COUNTING and ARMED->COUNTING (start), COUNTING->ARMED (stop, still configured), COUNTING->IDLE and ARMED->IDLE (deconfigure).

Top module: `pmc_top`

## Requirements
- R1: After reset every readable register returns 0 and both channels are in IDLE.
- R2: A control register (word 0 for channel 0, word 1 for channel 1) reads back the bits last written to it in these positions: bit 0 (enable), bit 1 (mode), bit 3 (start) and bits 16:6 (event select). All other bits read 0.
- R3: While start is 1, the counter adds exactly one in each cycle where the selected event is present. The event is chosen by the low 10 bits of the select field: 0x000 every cycle, 0x200 privileged cycles, 0x202 instructions (event bit 0), 0x204 branches (bit 1), 0x029 instruction cache accesses (bit 2), 0x02a instruction cache misses (bit 3), 0x031 operand cache read accesses (bit 4), 0x032 operand cache read misses (bit 5).
- R4: While start is 0, the count keeps its value whatever the events do.
- R5: A code whose low 10 bits match none of the codes in R3 selects nothing, so the count holds even while started. Bit 16 of the control register (the top bit of the select field) does not affect which event is selected.
- R6: Writing 1 to status bit 1 sets counter 0 and its overflow flag to 0 on the next edge; status bit 9 does the same for counter 1. A clear takes priority over an increment in the same cycle.
- R7: When a counter steps from all ones to 0, its overflow flag (status bit 3 for channel 0, bit 11 for channel 1) becomes 1. It stays 1 until that channel is cleared.
- R8: Status bits 0, 8, 16 and 24 are reserved. Writes to them have no effect, and they read 0. Every other status bit except 3 and 11 also reads 0.
- R9: Counter 0 is read at word 4 and counter 1 at word 5, zero-extended to 32 bits. Words 3, 6 and 7 read 0.
- R10: A control write with both configuration bits set and start 0 leaves the channel ARMED and not counting. A later write with start 1 begins counting from the value the counter held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EV | One-cycle event pulses from the processor model |
| priv_i | input | 1 | High while the processor is in privileged mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word index of the register written |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Word index of the register read |
| rd_data_o | output | 32 | Combinational read data |

## Verification
The bench builds the block with CNT_W set to 8. A counter on the every-cycle code then wraps within 256 cycles, so the overflow flag, its stickiness and its interaction with clear are all reached many times in a short run. The 32-bit default keeps the same logic, but its wrap point cannot be reached in a practical run. With the narrow counter, the zero-extension to 32-bit readback is also exercised across the whole counter range.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int DATA_W      = 32;
    localparam int NCH         = 2;
    localparam int SEL_FIELD_W = 11;
    localparam int SEL_CODE_W  = 10;

    // control register bit positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_MODE_BIT  = 1;
    localparam int CTL_START_BIT = 3;
    localparam int CTL_SEL_LSB   = 6;

    // word indices
    localparam int WA_CTL0 = 0;
    localparam int WA_STAT = 2;
    localparam int WA_CNT0 = 4;

    // event vector positions
    localparam int EV_INSTR   = 0;
    localparam int EV_BRANCH  = 1;
    localparam int EV_IC_ACC  = 2;
    localparam int EV_IC_MISS = 3;
    localparam int EV_OC_RACC = 4;
    localparam int EV_OC_RMIS = 5;
    localparam int EV_COUNT   = 6;

    // event-select codes (low 10 bits)
    localparam logic [SEL_CODE_W-1:0] SEL_CYCLES  = 10'h000;
    localparam logic [SEL_CODE_W-1:0] SEL_PRIV    = 10'h200;
    localparam logic [SEL_CODE_W-1:0] SEL_INSTR   = 10'h202;
    localparam logic [SEL_CODE_W-1:0] SEL_BRANCH  = 10'h204;
    localparam logic [SEL_CODE_W-1:0] SEL_IC_ACC  = 10'h029;
    localparam logic [SEL_CODE_W-1:0] SEL_IC_MISS = 10'h02a;
    localparam logic [SEL_CODE_W-1:0] SEL_OC_RACC = 10'h031;
    localparam logic [SEL_CODE_W-1:0] SEL_OC_RMIS = 10'h032;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_ARMED    = 2'd1,
        CH_COUNTING = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [SEL_FIELD_W-1:0] sel;
        logic                   start;
        logic                   mode;
        logic                   en;
    } ctl_t;

    function automatic int clr_bit(input int ch);
        return ch * 8 + 1;
    endfunction

    function automatic int ovf_bit(input int ch);
        return ch * 8 + 3;
    endfunction

endpackage

// File: rtl/pmc_evt_sel.sv
module pmc_evt_sel
    import pmc_pkg::*;
#(
    parameter int NUM_EV = EV_COUNT
) (
    input  logic [SEL_CODE_W-1:0] code_i,
    input  logic [NUM_EV-1:0]     evt_i,
    input  logic                  priv_i,
    output logic                  hit_o
);

    always_comb begin
        case (code_i)
            SEL_CYCLES:  hit_o = 1'b1;
            SEL_PRIV:    hit_o = priv_i;
            SEL_INSTR:   hit_o = evt_i[EV_INSTR];
            SEL_BRANCH:  hit_o = evt_i[EV_BRANCH];
            SEL_IC_ACC:  hit_o = evt_i[EV_IC_ACC];
            SEL_IC_MISS: hit_o = evt_i[EV_IC_MISS];
            SEL_OC_RACC: hit_o = evt_i[EV_OC_RACC];
            SEL_OC_RMIS: hit_o = evt_i[EV_OC_RMIS];
            default:     hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmc_chan.sv
module pmc_chan
    import pmc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  ctl_t             ctl_wr_i,
    input  logic             clr_i,
    input  logic             hit_i,
    output ctl_t             ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             counting_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ch_state_e state_q, state_d;
    logic      cfg_ok;

    assign cfg_ok = ctl_wr_i.mode & ctl_wr_i.en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctl_we_i && ctl_wr_i.start) state_d = CH_COUNTING;
                else if (ctl_we_i && cfg_ok)    state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (ctl_we_i && ctl_wr_i.start) state_d = CH_COUNTING;
                else if (ctl_we_i && !cfg_ok)   state_d = CH_IDLE;
            end
            CH_COUNTING: begin
                if (ctl_we_i && !ctl_wr_i.start) state_d = cfg_ok ? CH_ARMED : CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_COUNTING: counting_o = 1'b1;
            default:     counting_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctl_o <= '0;
        else if (ctl_we_i) ctl_o <= ctl_wr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else if (counting_o && hit_i) begin
            cnt_o <= cnt_o + 1'b1;
            if (cnt_o == CNT_MAX) ovf_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3,
    parameter int NUM_EV = EV_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] evt_i,
    input  logic              priv_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    ctl_t                       ctl_wr;
    ctl_t       [NCH-1:0]       ctl_q;
    logic       [NCH-1:0][CNT_W-1:0] cnt_q;
    logic       [NCH-1:0]       ovf_q;
    logic       [NCH-1:0]       counting;
    logic       [NCH-1:0]       hit;
    logic       [NCH-1:0]       clr;
    logic       [NCH-1:0]       ctl_we;
    logic                       unused_wr_bits;

    assign ctl_wr.sel   = wr_data_i[CTL_SEL_LSB +: SEL_FIELD_W];
    assign ctl_wr.start = wr_data_i[CTL_START_BIT];
    assign ctl_wr.mode  = wr_data_i[CTL_MODE_BIT];
    assign ctl_wr.en    = wr_data_i[CTL_EN_BIT];
    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:CTL_SEL_LSB+SEL_FIELD_W], wr_data_i[5:4], wr_data_i[2]};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign ctl_we[ch] = wr_en_i && (wr_addr_i == ADDR_W'(WA_CTL0 + ch));
        assign clr[ch]    = wr_en_i && (wr_addr_i == ADDR_W'(WA_STAT)) && wr_data_i[clr_bit(ch)];

        pmc_evt_sel #(.NUM_EV(NUM_EV)) u_sel (
            .code_i (ctl_q[ch].sel[SEL_CODE_W-1:0]),
            .evt_i  (evt_i),
            .priv_i (priv_i),
            .hit_o  (hit[ch])
        );

        pmc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we_i   (ctl_we[ch]),
            .ctl_wr_i   (ctl_wr),
            .clr_i      (clr[ch]),
            .hit_i      (hit[ch]),
            .ctl_o      (ctl_q[ch]),
            .cnt_o      (cnt_q[ch]),
            .ovf_o      (ovf_q[ch]),
            .counting_o (counting[ch])
        );
    end

    always_comb begin
        rd_data_o = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (rd_addr_i == ADDR_W'(WA_CTL0 + ch)) begin
                rd_data_o[CTL_SEL_LSB +: SEL_FIELD_W] = ctl_q[ch].sel;
                rd_data_o[CTL_START_BIT]              = ctl_q[ch].start;
                rd_data_o[CTL_MODE_BIT]               = ctl_q[ch].mode;
                rd_data_o[CTL_EN_BIT]                 = ctl_q[ch].en;
            end
            if (rd_addr_i == ADDR_W'(WA_CNT0 + ch))
                rd_data_o = DATA_W'(cnt_q[ch]);
            if (rd_addr_i == ADDR_W'(WA_STAT))
                rd_data_o[ovf_bit(ch)] = ovf_q[ch];
        end
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCH-1:0][CNT_W-1:0]  cnt,
    input logic [NCH-1:0]             ovf,
    input logic [NCH-1:0]             counting,
    input logic [NCH-1:0]             hit,
    input logic [NCH-1:0]             clr,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic [DATA_W-1:0]          rd_data
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (counting[ch] && hit[ch] && !clr[ch]) |=> (cnt[ch] == CNT_W'($past(cnt[ch]) + 1'b1))); // R3
        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!counting[ch] && !clr[ch]) |=> $stable(cnt[ch])); // R4
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr[ch] |=> (cnt[ch] == '0 && !ovf[ch])); // R6
        AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (counting[ch] && hit[ch] && !clr[ch] && cnt[ch] == {CNT_W{1'b1}}) |=> (ovf[ch] && cnt[ch] == '0)); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[ch] && !clr[ch]) |=> ovf[ch]); // R7
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(WA_STAT)) |-> (rd_data[0] == 1'b0 && rd_data[8] == 1'b0 &&
                                           rd_data[16] == 1'b0 && rd_data[24] == 1'b0)); // R8

endmodule

bind pmc_top pmc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pmc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .ovf      (ovf_q),
    .counting (counting),
    .hit      (hit),
    .clr      (clr),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o)
);

// File: tb/test_pmc_top.sv
`timescale 1ns/100ps
module test_pmc_top;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NEV    = 6;
    localparam logic [31:0] CTL_MASK = 32'h0001_FFCB;
    localparam logic [31:0] CNT_MASK = (32'h1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NEV-1:0]    evt = '0;
    logic              priv = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string phase = "R1";

    logic [31:0] m_ctl [2];
    logic [31:0] m_cnt [2];
    logic        m_ovf [2];

    always #5 clk = ~clk;

    pmc_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_EV(NEV)) i_pmc_top (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    function automatic logic sel_hit(input logic [9:0] code, input logic [NEV-1:0] e, input logic p);
        case (code)
            10'h000: return 1'b1;
            10'h200: return p;
            10'h202: return e[0];
            10'h204: return e[1];
            10'h029: return e[2];
            10'h02a: return e[3];
            10'h031: return e[4];
            10'h032: return e[5];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return m_ctl[0];
            1: return m_ctl[1];
            2: return (32'(m_ovf[0]) << 3) | (32'(m_ovf[1]) << 11);
            4: return m_cnt[0];
            5: return m_cnt[1];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string reg_tag(input int a);
        case (a)
            0, 1: return "R2";
            2: return "R7";
            4, 5: return "R3";
            default: return "R9";
        endcase
    endfunction

    // reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ctl[c] = '0; m_cnt[c] = '0; m_ovf[c] = 1'b0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (wr_en && wr_addr == 3'd2 && wr_data[c*8+1]) begin
                    m_cnt[c] = '0; m_ovf[c] = 1'b0;
                end else if (m_ctl[c][3] && sel_hit(m_ctl[c][15:6], evt, priv)) begin
                    if (m_cnt[c] == CNT_MASK) m_ovf[c] = 1'b1;
                    m_cnt[c] = (m_cnt[c] + 1) & CNT_MASK;
                end
            end
            for (int c = 0; c < 2; c++)
                if (wr_en && wr_addr == ADDR_W'(c)) m_ctl[c] = wr_data & CTL_MASK;
        end
    end

    task automatic check_all();
        for (int a = 0; a < 8; a++) begin
            rd_addr = ADDR_W'(a);
            #0.4;
            n_checks++;
            if (rd_data !== exp_read(a)) begin
                n_fail++;
                $display("FAIL %s (phase %s) word %0d: actual %h expected %h",
                         reg_tag(a), phase, a, rd_data, exp_read(a));
            end
        end
    endtask

    // one cycle: check, then drive the next inputs
    task automatic step(input logic we, input int wa, input logic [31:0] wd,
                        input logic [NEV-1:0] e, input logic p);
        @(negedge clk);
        check_all();
        wr_en = we; wr_addr = ADDR_W'(wa); wr_data = wd; evt = e; priv = p;
    endtask

    task automatic idle_cycles(input int n, input logic [NEV-1:0] e, input logic p);
        for (int k = 0; k < n; k++) step(1'b0, 0, 32'h0, e, p);
    endtask

    function automatic logic [31:0] ctl_word(input logic [10:0] sel, input logic start);
        return (32'(sel) << 6) | (32'(start) << 3) | 32'h3;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1";
        check_all();
        rst_n = 1'b1;
        idle_cycles(2, '1, 1'b1);

        // R10: configure without start, then start
        phase = "R10";
        step(1'b1, 2, 32'h0000_0202, '0, 1'b0);
        step(1'b1, 0, ctl_word(11'h202, 1'b0), '0, 1'b0);
        idle_cycles(5, 6'b000001, 1'b0);
        step(1'b1, 0, ctl_word(11'h202, 1'b1), 6'b000001, 1'b0);
        phase = "R3";
        for (int k = 0; k < 20; k++) step(1'b0, 0, 0, NEV'(k), k[0]);

        // R4: stop freezes
        phase = "R4";
        step(1'b1, 0, ctl_word(11'h202, 1'b0), '1, 1'b1);
        idle_cycles(8, '1, 1'b1);

        // R5: unknown code and ignored top select bit
        phase = "R5";
        step(1'b1, 1, ctl_word(11'h155, 1'b1), '1, 1'b1);
        idle_cycles(6, '1, 1'b1);
        step(1'b1, 1, ctl_word(11'h600, 1'b1), '0, 1'b1);
        for (int k = 0; k < 10; k++) step(1'b0, 0, 0, '0, k[1]);

        // R6: clear wins over increment
        phase = "R6";
        step(1'b1, 0, ctl_word(11'h000, 1'b1), '0, 1'b0);
        idle_cycles(4, '0, 1'b0);
        step(1'b1, 2, 32'h0000_0202, '0, 1'b1);
        idle_cycles(3, '0, 1'b0);

        // R7: wrap on channel 1 with every-cycle code
        phase = "R7";
        step(1'b1, 2, 32'h0000_0200, '0, 1'b0);
        step(1'b1, 1, ctl_word(11'h000, 1'b1), '0, 1'b0);
        idle_cycles(300, '0, 1'b0);

        // R8: reserved status bits ignored
        phase = "R8";
        step(1'b1, 2, 32'h0101_0101, '1, 1'b1);
        step(1'b1, 2, 32'hFFFF_FFFF & ~32'h0101_0202, '1, 1'b1);
        idle_cycles(3, '0, 1'b0);

        // random phase
        phase = "R9";
        begin
            int unsigned seed_dummy;
            logic [10:0] codes [9];
            codes = '{11'h000, 11'h200, 11'h202, 11'h204, 11'h029, 11'h02a, 11'h031, 11'h032, 11'h0f3};
            seed_dummy = $urandom(32'd12345);
            for (int k = 0; k < 4000; k++) begin
                logic [31:0] wd;
                int wa;
                logic we;
                we = ($urandom % 8) == 0;
                wa = $urandom % 8;
                wd = $urandom;
                if (wa == 0 || wa == 1) begin
                    wd[16:6] = codes[$urandom % 9] | (11'($urandom % 2) << 10);
                    if (($urandom % 3) != 0) wd[1:0] = 2'b11;
                end else if (wa == 2) begin
                    wd = wd & ~32'h0101_0101;
                    if (($urandom % 4) != 0) wd = wd & ~32'h0000_0202;
                end
                step(we, wa, wd, NEV'($urandom), 1'($urandom));
            end
        end

        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule